// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a small clocked memory with the command interface of a synchronous SRAM. Every rising clock edge samples a command made from a sleep input, an active-low select, an active-low write strobe, active-low lane write enables, an active-low output enable and an advance input. Reads are pipelined: the addressed word appears on the read data port in the cycle after the command. Writes are late: the write command carries the address and lane enables, and the data to store is sampled on the following clock edge.

A read or write opens a burst context. While select is high, the advance input continues that burst at the next word above the registered base address. A 2-bit offset wraps, so a fourth continue returns to the base address. There are no tristate pads: the output is a data bus plus a drive flag. When a read hits the address of a write whose data is being committed on the same edge, the merged new word is returned, not the stale one.

Top module: `sram_lw`

## Requirements
- R1: A read (sleep low, `sel_n` low, `wr_n` high) with `oe_n` low drives `rdata_oe` high in the following cycle, and `rdata` then holds the word stored at `addr`.
- R2: A read with `oe_n` high leaves `rdata_oe` low in the following cycle.
- R3: A write (`sel_n` low, `wr_n` low) with both lane enables low stores the `wdata` sampled on the next clock edge into every lane at `addr`. Lane enable bit 0 covers `wdata[8:0]` and bit 1 covers `wdata[17:9]`.
- R4: A write with only one lane enable low updates only that lane and leaves the other lane of the word unchanged.
- R5: A write with both lane enables high is aborted: the memory is unchanged and `rdata_oe` is low in the following cycle.
- R6: After a deselect (`sel_n` high, `adv` low) or any write, `rdata_oe` is low in the following cycle.
- R7: While `sleep` is high, `rdata_oe` is low in that cycle and the next. All other inputs are ignored, including the data phase of a pending write, which is dropped. Any open burst ends.
- R8: With `sel_n` high and `adv` high after a read or write, the burst repeats the same operation at base+1, base+2 and base+3, modulo the depth. A fourth continue returns to the base address. Each continue uses its own `oe_n` or lane enables.
- R9: A continue with no open burst (after reset, a deselect or sleep) behaves as a deselect.
- R10: A read at the address of a write whose data phase falls on the same edge returns the merged new word.
- R11: Reset (`rst_n` low) forces `rdata_oe` low, discards a pending write and closes any burst. Memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sleep | input | 1 | High: ignore all other inputs and keep the output released |
| sel_n | input | 1 | Active-low select; low starts a read or write |
| wr_n | input | 1 | Active-low write strobe, sampled with select |
| adv | input | 1 | Continue the open burst while select is high |
| oe_n | input | 1 | Active-low output enable for reads |
| lane_en_n | input | LANES | Active-low lane write enables |
| addr | input | ADDR_W | Word address for a new command |
| wdata | input | LANES*LANE_W | Write data, sampled one edge after its write command |
| rdata | output | LANES*LANE_W | Read data, valid while `rdata_oe` is high |
| rdata_oe | output | 1 | Output drive flag, stands in for tristate enable |

## Verification
The bench uses the default parameters: 16 words of two 9-bit lanes. With a depth this small, random addresses collide often. This gives frequent read-after-write forwarding hits, and bursts from high base addresses wrap both the 2-bit offset and the address. Two lanes are enough to reach full, partial and aborted writes, each with its own encoding.

// File: rtl/sram_lw_pkg.sv
package sram_lw_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;
endpackage

// File: rtl/sram_lw_decode.sv
module sram_lw_decode
  import sram_lw_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int LANES   = 2,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              adv,
  input  logic              oe_n,
  input  logic [LANES-1:0]  lane_en_n,
  input  logic [ADDR_W-1:0] addr,
  output sram_op_e          op,
  output logic [ADDR_W-1:0] op_addr,
  output logic [LANES-1:0]  op_lanes,
  output logic              op_drive
);
  logic               act_q, act_n;
  logic               bwr_q, bwr_n;
  logic [ADDR_W-1:0]  base_q, base_n;
  logic [BURST_W-1:0] off_q, off_n;
  logic               ctx_load;

  always_comb begin
    act_n    = act_q;
    bwr_n    = bwr_q;
    base_n   = base_q;
    off_n    = off_q;
    op       = OP_IDLE;
    op_addr  = addr;
    op_lanes = '0;
    op_drive = 1'b0;
    ctx_load = 1'b0;
    if (sleep) begin
      act_n = 1'b0;
    end else if (!sel_n) begin
      ctx_load = 1'b1;
      act_n    = 1'b1;
      bwr_n    = !wr_n;
      base_n   = addr;
      off_n    = '0;
      op       = wr_n ? OP_READ : OP_WRITE;
      op_addr  = addr;
      op_lanes = ~lane_en_n;
      op_drive = wr_n && !oe_n;
    end else if (adv && act_q) begin
      ctx_load = 1'b1;
      off_n    = off_q + 1'b1;
      op       = bwr_q ? OP_WRITE : OP_READ;
      op_addr  = base_q + ADDR_W'(off_n);
      op_lanes = ~lane_en_n;
      op_drive = !bwr_q && !oe_n;
    end else begin
      act_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_n;
  end

  always_ff @(posedge clk) begin
    if (ctx_load) begin
      bwr_q  <= bwr_n;
      base_q <= base_n;
      off_q  <= off_n;
    end
  end
endmodule

// File: rtl/sram_lw_array.sv
module sram_lw_array #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we_lanes,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rword
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    always_ff @(posedge clk) begin
      if (we_lanes[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rword[g*LANE_W +: LANE_W] = cells[raddr];
  end
endmodule

// File: rtl/sram_lw_outpipe.sv
module sram_lw_outpipe #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep,
  input  logic                    rd_en,
  input  logic                    rd_drive,
  input  logic [LANES*LANE_W-1:0] arr_word,
  input  logic                    fwd_hit,
  input  logic [LANES-1:0]        fwd_lanes,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] q_q;
  logic              drv_q, drv_n;

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g*LANE_W +: LANE_W] = (fwd_hit && fwd_lanes[g]) ?
        wdata[g*LANE_W +: LANE_W] : arr_word[g*LANE_W +: LANE_W];
  end

  always_comb begin
    drv_n = rd_en && rd_drive;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_q <= 1'b0;
    else        drv_q <= drv_n;
  end

  always_ff @(posedge clk) begin
    if (rd_en) q_q <= merged;
  end

  assign rdata    = q_q;
  assign rdata_oe = drv_q && !sleep;
endmodule

// File: rtl/sram_lw.sv
module sram_lw
  import sram_lw_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int LANES   = 2,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep,
  input  logic                    sel_n,
  input  logic                    wr_n,
  input  logic                    adv,
  input  logic                    oe_n,
  input  logic [LANES-1:0]        lane_en_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);
  localparam int DATA_W = LANES * LANE_W;

  sram_op_e          op;
  logic [ADDR_W-1:0] op_addr;
  logic [LANES-1:0]  op_lanes;
  logic              op_drive;

  logic              pend_v_q, pend_v_n;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [LANES-1:0]  pend_lanes_q;
  logic              commit;
  logic [LANES-1:0]  we_lanes;
  logic              fwd_hit;
  logic [DATA_W-1:0] arr_word;

  sram_lw_decode #(
    .ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel_n(sel_n), .wr_n(wr_n),
    .adv(adv), .oe_n(oe_n), .lane_en_n(lane_en_n), .addr(addr),
    .op(op), .op_addr(op_addr), .op_lanes(op_lanes), .op_drive(op_drive)
  );

  always_comb begin
    pend_v_n = (op == OP_WRITE);
    commit   = pend_v_q && !sleep;
    we_lanes = commit ? pend_lanes_q : '0;
    fwd_hit  = commit && (pend_addr_q == op_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_v_q <= 1'b0;
    else        pend_v_q <= pend_v_n;
  end

  always_ff @(posedge clk) begin
    if (pend_v_n) begin
      pend_addr_q  <= op_addr;
      pend_lanes_q <= op_lanes;
    end
  end

  sram_lw_array #(
    .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
  ) u_array (
    .clk(clk), .we_lanes(we_lanes), .waddr(pend_addr_q), .wdata(wdata),
    .raddr(op_addr), .rword(arr_word)
  );

  sram_lw_outpipe #(
    .LANES(LANES), .LANE_W(LANE_W)
  ) u_out (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .rd_en(op == OP_READ),
    .rd_drive(op_drive), .arr_word(arr_word), .fwd_hit(fwd_hit),
    .fwd_lanes(pend_lanes_q), .wdata(wdata), .rdata(rdata),
    .rdata_oe(rdata_oe)
  );
endmodule

// File: rtl/sram_lw_chk.sv
module sram_lw_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep,
  input logic sel_n,
  input logic wr_n,
  input logic adv,
  input logic oe_n,
  input logic rdata_oe
);
  // R7
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !rdata_oe);

  // R6
  desel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && sel_n && !adv) |=> !rdata_oe);

  // R6
  write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !sel_n && !wr_n) |=> !rdata_oe);

  // R2
  read_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !sel_n && wr_n && oe_n) |=> !rdata_oe);

  // R1
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !sel_n && wr_n && !oe_n) |=> (rdata_oe || sleep));
endmodule

bind sram_lw sram_lw_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel_n(sel_n), .wr_n(wr_n),
  .adv(adv), .oe_n(oe_n), .rdata_oe(rdata_oe)
);

// File: tb/sram_lw_test.sv
module sram_lw_test;
  localparam int CLK_P = 10;
  localparam int AW = 4;
  localparam int LN = 2;
  localparam int LW = 9;
  localparam int DW = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep = 1'b0, sel_n = 1'b1, wr_n = 1'b1, adv = 1'b0, oe_n = 1'b0;
  logic [LN-1:0] lane_en_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rdata_oe;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // bench reference state
  logic [DW-1:0] mem_m [DEPTH];
  logic          pv_m, act_m, bwr_m, drv_m;
  logic [AW-1:0] pa_m, base_m;
  logic [LN-1:0] pl_m;
  logic [1:0]    off_m;
  logic [DW-1:0] q_m;
  string         tag_m;

  always #(CLK_P/2) clk = ~clk;

  sram_lw uut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel_n(sel_n), .wr_n(wr_n),
    .adv(adv), .oe_n(oe_n), .lane_en_n(lane_en_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  function automatic logic [DW-1:0] lane_merge(logic [DW-1:0] old_w,
      logic [DW-1:0] new_w, logic [LN-1:0] en);
    logic [DW-1:0] r = old_w;
    for (int l = 0; l < LN; l++)
      if (en[l]) r[l*LW +: LW] = new_w[l*LW +: LW];
    return r;
  endfunction

  task automatic model_clear();
    pv_m = 0; act_m = 0; drv_m = 0; tag_m = "R11";
  endtask

  task automatic model_read(logic [AW-1:0] a, bit hit);
    q_m   = mem_m[a];
    drv_m = !oe_n;
    tag_m = hit ? "R10" : (oe_n ? "R2" : "R1");
  endtask

  task automatic model_edge();
    bit            was_pv = pv_m;
    logic [AW-1:0] was_pa = pa_m;
    logic [AW-1:0] a;
    if (!sleep && pv_m) mem_m[pa_m] = lane_merge(mem_m[pa_m], wdata, pl_m);
    pv_m  = 0;
    drv_m = 0;
    if (sleep) begin
      act_m = 0; tag_m = "R7";
    end else if (!sel_n) begin
      act_m = 1; bwr_m = !wr_n; base_m = addr; off_m = 0;
      if (wr_n) model_read(addr, was_pv && was_pa == addr);
      else begin
        pv_m = 1; pa_m = addr; pl_m = ~lane_en_n;
        tag_m = (lane_en_n == '1) ? "R5" : ((lane_en_n == '0) ? "R3" : "R4");
      end
    end else if (adv && act_m) begin
      off_m = off_m + 2'd1;
      a = base_m + AW'(off_m);
      if (bwr_m) begin
        pv_m = 1; pa_m = a; pl_m = ~lane_en_n; tag_m = "R8";
      end else begin
        model_read(a, was_pv && was_pa == a);
        if (tag_m != "R10") tag_m = "R8";
      end
    end else begin
      act_m = 0; tag_m = adv ? "R9" : "R6";
    end
  endtask

  task automatic check_out(string req);
    logic exp_oe = drv_m && !sleep;
    vectors++;
    if (rdata_oe !== exp_oe) begin
      miscompares++;
      $display("FAIL %s: rdata_oe=%b expected %b at %0t", req, rdata_oe, exp_oe, $time);
    end else if (exp_oe && rdata !== q_m) begin
      miscompares++;
      $display("FAIL %s: rdata=%h expected %h at %0t", req, rdata, q_m, $time);
    end
  endtask

  // drive one command, check the output of the previous one, then clock it
  task automatic cyc(bit s, bit sn, bit wn, bit ad, bit on, logic [LN-1:0] ln,
      logic [AW-1:0] a, logic [DW-1:0] wd);
    @(negedge clk);
    sleep = s; sel_n = sn; wr_n = wn; adv = ad; oe_n = on;
    lane_en_n = ln; addr = a; wdata = wd;
    #1 check_out(tag_m);
    @(posedge clk);
    model_edge();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; sleep = 0; sel_n = 1; adv = 0;
    model_clear();
    #1 check_out("R11");
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
    model_clear();
    #2 check_out("R11");
    do_reset();

    // R9: continue straight after reset
    cyc(0, 1, 1, 1, 0, 2'b11, 4'd0, '0);
    cyc(0, 1, 1, 0, 0, 2'b11, 4'd0, '0);
    // R3: fill every word with full writes, data one edge late
    for (int i = 0; i < DEPTH; i++)
      cyc(0, 0, 0, 0, 0, 2'b00, AW'(i), DW'(18'h15a5a + 37 * (i - 1)));
    cyc(0, 1, 1, 0, 0, 2'b11, 4'd0, DW'(18'h15a5a + 37 * (DEPTH - 1)));
    // R8: read burst from 14 wraps address and offset back to base
    cyc(0, 0, 1, 0, 0, 2'b11, 4'd14, '0);
    for (int k = 0; k < 4; k++) cyc(0, 1, 1, 1, 0, 2'b11, 4'd0, '0);
    // R4: upper lane only, then lower lane only
    cyc(0, 0, 0, 0, 0, 2'b01, 4'd3, '0);
    cyc(0, 0, 0, 0, 0, 2'b10, 4'd4, 18'h3ffff);
    cyc(0, 0, 1, 0, 0, 2'b11, 4'd3, 18'h2aaaa);
    cyc(0, 0, 1, 0, 0, 2'b11, 4'd4, '0);
    // R5: aborted write, then read back
    cyc(0, 0, 0, 0, 0, 2'b11, 4'd6, '0);
    cyc(0, 0, 1, 0, 0, 2'b11, 4'd6, 18'h12345);
    // R10: read right behind a write to the same word
    cyc(0, 0, 0, 0, 0, 2'b10, 4'd7, '0);
    cyc(0, 0, 1, 0, 0, 2'b11, 4'd7, 18'h0beef);
    // R8: write burst, then R2 masked read
    cyc(0, 0, 0, 0, 0, 2'b00, 4'd8, '0);
    for (int k = 0; k < 3; k++) cyc(0, 1, 1, 1, 0, 2'b00, 4'd0, DW'(18'h01111 * (k + 1)));
    cyc(0, 0, 1, 0, 1, 2'b11, 4'd9, 18'h03333);
    cyc(0, 0, 1, 0, 0, 2'b11, 4'd10, '0);
    // R7: sleep in the cycle after a read, and on a write data phase
    cyc(0, 0, 1, 0, 0, 2'b11, 4'd1, '0);
    cyc(1, 0, 1, 0, 0, 2'b11, 4'd1, '0);
    cyc(0, 0, 0, 0, 0, 2'b00, 4'd2, '0);
    cyc(1, 0, 1, 0, 0, 2'b11, 4'd2, 18'h3c3c3);
    cyc(0, 1, 1, 1, 0, 2'b11, 4'd0, '0);
    cyc(0, 0, 1, 0, 0, 2'b11, 4'd2, '0);
    // R11: reset between a write command and its data phase
    cyc(0, 0, 0, 0, 0, 2'b00, 4'd5, '0);
    do_reset();
    cyc(0, 1, 1, 0, 0, 2'b11, 4'd0, 18'h2d2d2);
    cyc(0, 0, 1, 0, 0, 2'b11, 4'd5, '0);
    cyc(0, 1, 1, 0, 0, 2'b11, 4'd0, '0);

    // constrained random mix
    for (int n = 0; n < 6000; n++) begin
      int pick = $urandom_range(99);
      bit s = 0, sn = 1, wn = 1, ad = 0;
      if (pick < 5) s = 1;
      else if (pick < 35) begin sn = 0; wn = 1; end
      else if (pick < 62) begin sn = 0; wn = 0; end
      else if (pick < 90) ad = 1;
      cyc(s, sn, wn, ad, ($urandom_range(4) == 0), LN'($urandom),
          AW'($urandom), DW'($urandom));
    end
    cyc(0, 1, 1, 0, 0, 2'b11, 4'd0, '0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule